// File: doc/BRIEF.md
# Five-Stage Pipelined Load/Store Processor Core

This block is a 32-bit in-order processor core with five stages: fetch, decode with register read, execute, memory access and write-back. Every instruction is one 32-bit word. The core runs a fixed-format subset of eight operations:

- word load and word store
- add, subtract, and, or
- signed set-less-than
- branch-if-equal

Only the load and store instructions touch data memory. Their address is formed in the execute stage and used in the next stage. Instruction memory and data memory are small internal word arrays.

The core has two operating phases, selected by the `run` pin. While `run` is low, the pipeline is empty, the program counter is held at zero and the load port accepts words. The load port uses a valid/ready handshake: a word is accepted on any clock edge where `ld_valid` and `ld_ready` are both high. `ld_ready` is high exactly while `run` is low, so any write offered while the core runs is refused rather than queued.

When `run` goes high, fetch starts at address 0. A program ends by branching to itself. The debug ports read the register file and data memory combinationally at any time.

The core does not forward results between stages. When an instruction depends on a result that is not yet available, the core stalls it. The register file writes in the first half of a cycle and reads in the second, so a write-back and a decode of the same register may share a cycle.

Top module: `pipe_core`

## Requirements
- R1: After reset all 32 registers read zero on the debug port, and `ld_ready` is high while `run` is low.
- R2: With `run` low, a handshake on the load port writes `ld_data` at word index `ld_addr`. The target is instruction memory when `ld_sel` is 0 and data memory when `ld_sel` is 1. A data word written this way reads back on `dbg_mem_data`.
- R3: Register-type instructions have opcode 0x00 in bits 31..26. The sources are bits 25..21 and 20..16, and the destination is bits 15..11. Function code 0x20 in bits 5..0 adds, 0x22 subtracts (first source minus second), 0x24 ands and 0x25 ors. Any other function code does nothing.
- R4: Function code 0x2A writes 1 when the first source is less than the second as signed 32-bit values, and 0 otherwise.
- R5: Load (opcode 0x23) writes register bits 20..16 with the data word at base register (bits 25..21) plus the sign-extended immediate (bits 15..0). Store (opcode 0x2B) writes register bits 20..16 to that address. The word index is the address divided by four.
- R6: Register 0 always reads zero, and writing it has no effect.
- R7: A dependent sequence gives the same results as sequential execution. This covers a load followed at once by a use of its result. When decode reads a register that an instruction in execute or memory will write, fetch and decode hold and a bubble enters execute.
- R8: An instruction three slots after a writer reads the new value without stalling, because write-back and decode share a cycle.
- R9: A branch-if-equal instruction (opcode 0x04) compares registers 25..21 and 20..16 in execute. If they are equal, the two younger instructions are discarded and fetch resumes at the branch address plus 4 plus the sign-extended immediate times four. If they are not equal, execution continues in order.
- R10: While `run` is high, `ld_ready` is low and the load port changes no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High: execute from address 0; low: idle, pipeline empty |
| ld_valid | input | 1 | Load port word offered |
| ld_ready | output | 1 | Load port can accept (high while idle) |
| ld_sel | input | 1 | 0 = instruction memory, 1 = data memory |
| ld_addr | input | MEM_AW | Load port word index |
| ld_data | input | 32 | Load port word |
| dbg_reg_addr | input | 5 | Register number to observe |
| dbg_reg_data | output | 32 | Value of that register |
| dbg_mem_addr | input | MEM_AW | Data memory word index to observe |
| dbg_mem_data | output | 32 | Value of that data word |

## Verification
The assertions assume three things about the inputs:

- `run` rises only after instruction memory holds a complete program that ends in a branch to itself.
- Every load and store address stays within the data array.
- The load port is used only while `run` is low.

Under these assumptions a stall must freeze the program counter and empty execute, and a taken branch must empty the two younger slots. The stimulus respects the assumptions: every program is loaded while `run` is low, the rest of instruction memory is filled with no-op words, and every program ends in a self-branch. The one deliberate break is a load attempt while running, made to check that it is refused.

// File: rtl/pipe_pkg.sv
package pipe_pkg;
  localparam int XW = 32;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_t;

  typedef struct packed {
    logic       reg_we;
    logic       mem_rd;
    logic       mem_wr;
    logic       branch;
    logic       use_imm;
    logic       rd_rs;
    logic       rd_rt;
    alu_op_t    alu;
    logic [4:0] dest;
  } ctrl_t;
endpackage

// File: rtl/pipe_decode.sv
module pipe_decode
  import pipe_pkg::*;
(
  input  logic [XW-1:0] instr,
  output ctrl_t         ctrl,
  output logic [4:0]    rs,
  output logic [4:0]    rt,
  output logic [XW-1:0] imm
);
  logic [5:0] op;
  logic [5:0] fn;
  logic [4:0] rd;

  assign op  = instr[31:26];
  assign fn  = instr[5:0];
  assign rd  = instr[15:11];
  assign rs  = instr[25:21];
  assign rt  = instr[20:16];
  assign imm = {{(XW-16){instr[15]}}, instr[15:0]};

  always_comb begin
    ctrl = '0;
    ctrl.alu = ALU_ADD;
    unique case (op)
      OP_RTYPE: begin
        ctrl.rd_rs = 1'b1;
        ctrl.rd_rt = 1'b1;
        ctrl.dest  = rd;
        ctrl.reg_we = 1'b1;
        unique case (fn)
          FN_ADD: ctrl.alu = ALU_ADD;
          FN_SUB: ctrl.alu = ALU_SUB;
          FN_AND: ctrl.alu = ALU_AND;
          FN_OR:  ctrl.alu = ALU_OR;
          FN_SLT: ctrl.alu = ALU_SLT;
          default: begin
            ctrl.reg_we = 1'b0;
            ctrl.rd_rs  = 1'b0;
            ctrl.rd_rt  = 1'b0;
          end
        endcase
      end
      OP_LOAD: begin
        ctrl.rd_rs   = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.mem_rd  = 1'b1;
        ctrl.reg_we  = 1'b1;
        ctrl.dest    = rt;
      end
      OP_STORE: begin
        ctrl.rd_rs   = 1'b1;
        ctrl.rd_rt   = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.mem_wr  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.rd_rs  = 1'b1;
        ctrl.rd_rt  = 1'b1;
        ctrl.branch = 1'b1;
        ctrl.alu    = ALU_SUB;
      end
      default: ;
    endcase
    if (ctrl.dest == 5'd0) ctrl.reg_we = 1'b0;
  end
endmodule

// File: rtl/pipe_alu.sv
module pipe_alu
  import pipe_pkg::*;
(
  input  alu_op_t       op,
  input  logic [XW-1:0] a,
  input  logic [XW-1:0] b,
  output logic [XW-1:0] y
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(XW-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/pipe_regfile.sv
module pipe_regfile
  import pipe_pkg::*;
#(
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [XW-1:0]           wdata,
  input  logic [$clog2(NREG)-1:0] ra1,
  output logic [XW-1:0]           rd1,
  input  logic [$clog2(NREG)-1:0] ra2,
  output logic [XW-1:0]           rd2,
  input  logic [$clog2(NREG)-1:0] ra3,
  output logic [XW-1:0]           rd3
);
  localparam int RW = $clog2(NREG);

  logic [XW-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  // A write in flight is visible to reads in the same cycle.
  function automatic logic [XW-1:0] rd_port(input logic [RW-1:0] a);
    if (a == '0)                 return '0;
    else if (we && waddr == a)   return wdata;
    else                         return regs[a];
  endfunction

  assign rd1 = rd_port(ra1);
  assign rd2 = rd_port(ra2);
  assign rd3 = (ra3 == '0) ? '0 : regs[ra3];
endmodule

// File: rtl/pipe_hazard.sv
module pipe_hazard (
  input  logic       id_valid,
  input  logic       id_rd_rs,
  input  logic       id_rd_rt,
  input  logic [4:0] id_rs,
  input  logic [4:0] id_rt,
  input  logic       ex_valid,
  input  logic       ex_we,
  input  logic [4:0] ex_dest,
  input  logic       mem_valid,
  input  logic       mem_we,
  input  logic [4:0] mem_dest,
  output logic       stall
);
  logic [1:0] hit;

  for (genvar g = 0; g < 2; g++) begin : g_src
    logic       used;
    logic [4:0] src;
    assign used = (g == 0) ? id_rd_rs : id_rd_rt;
    assign src  = (g == 0) ? id_rs : id_rt;
    assign hit[g] = used && (src != 5'd0) &&
                    ((ex_valid && ex_we && ex_dest == src) ||
                     (mem_valid && mem_we && mem_dest == src));
  end

  assign stall = id_valid && (hit != 2'b00);
endmodule

// File: rtl/pipe_core.sv
module pipe_core
  import pipe_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic              ld_sel,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [XW-1:0]     ld_data,
  input  logic [4:0]        dbg_reg_addr,
  output logic [XW-1:0]     dbg_reg_data,
  input  logic [MEM_AW-1:0] dbg_mem_addr,
  output logic [XW-1:0]     dbg_mem_data
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [XW-1:0] imem [DEPTH];
  logic [XW-1:0] dmem [DEPTH];

  // fetch
  logic [XW-1:0] pc;
  logic [XW-1:0] pc_next4;
  logic [XW-1:0] fetch_word;

  // fetch / decode register
  logic          ifid_valid;
  logic [XW-1:0] ifid_instr;
  logic [XW-1:0] ifid_pc4;

  // decode outputs
  ctrl_t         id_ctrl;
  logic [4:0]    id_rs, id_rt;
  logic [XW-1:0] id_imm, id_a, id_b;

  // decode / execute register
  logic          idex_valid;
  ctrl_t         idex_ctrl;
  logic [XW-1:0] idex_a, idex_b, idex_imm, idex_pc4;

  // execute
  logic [XW-1:0] ex_opb, ex_y;
  logic          br_taken;
  logic [XW-1:0] br_target;
  logic          stall;

  // execute / memory register
  logic          exmem_valid;
  logic          exmem_we, exmem_rd, exmem_wr;
  logic [4:0]    exmem_dest;
  logic [XW-1:0] exmem_y, exmem_store;

  // memory / write-back register
  logic          memwb_valid;
  logic          memwb_we;
  logic [4:0]    memwb_dest;
  logic [XW-1:0] memwb_data;

  logic          rf_we;
  logic [4:0]    rf_waddr;
  logic          ld_fire;
  logic          dm_we;
  logic [MEM_AW-1:0] dm_idx;
  logic [XW-1:0] mem_result;

  assign ld_ready = !run;
  assign ld_fire  = ld_valid && ld_ready;

  // ---------------- fetch ----------------
  assign pc_next4   = pc + 32'd4;
  assign fetch_word = imem[pc[MEM_AW+1:2]];

  always_ff @(posedge clk) begin
    if (ld_fire && !ld_sel) imem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc         <= '0;
      ifid_valid <= 1'b0;
      ifid_instr <= '0;
      ifid_pc4   <= '0;
    end else if (!run) begin
      pc         <= '0;
      ifid_valid <= 1'b0;
    end else if (br_taken) begin
      pc         <= br_target;
      ifid_valid <= 1'b0;
    end else if (!stall) begin
      pc         <= pc_next4;
      ifid_valid <= 1'b1;
      ifid_instr <= fetch_word;
      ifid_pc4   <= pc_next4;
    end
  end

  // ---------------- decode ----------------
  pipe_decode u_dec (
    .instr (ifid_instr),
    .ctrl  (id_ctrl),
    .rs    (id_rs),
    .rt    (id_rt),
    .imm   (id_imm)
  );

  pipe_regfile #(.NREG(32)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (memwb_data),
    .ra1   (id_rs),
    .rd1   (id_a),
    .ra2   (id_rt),
    .rd2   (id_b),
    .ra3   (dbg_reg_addr),
    .rd3   (dbg_reg_data)
  );

  pipe_hazard u_haz (
    .id_valid  (ifid_valid),
    .id_rd_rs  (id_ctrl.rd_rs),
    .id_rd_rt  (id_ctrl.rd_rt),
    .id_rs     (id_rs),
    .id_rt     (id_rt),
    .ex_valid  (idex_valid),
    .ex_we     (idex_ctrl.reg_we),
    .ex_dest   (idex_ctrl.dest),
    .mem_valid (exmem_valid),
    .mem_we    (exmem_we),
    .mem_dest  (exmem_dest),
    .stall     (stall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idex_valid <= 1'b0;
      idex_ctrl  <= '0;
      idex_a     <= '0;
      idex_b     <= '0;
      idex_imm   <= '0;
      idex_pc4   <= '0;
    end else if (!run || br_taken || stall) begin
      idex_valid <= 1'b0;
    end else begin
      idex_valid <= ifid_valid;
      idex_ctrl  <= id_ctrl;
      idex_a     <= id_a;
      idex_b     <= id_b;
      idex_imm   <= id_imm;
      idex_pc4   <= ifid_pc4;
    end
  end

  // ---------------- execute ----------------
  assign ex_opb = idex_ctrl.use_imm ? idex_imm : idex_b;

  pipe_alu u_alu (
    .op (idex_ctrl.alu),
    .a  (idex_a),
    .b  (ex_opb),
    .y  (ex_y)
  );

  assign br_taken  = idex_valid && idex_ctrl.branch && (ex_y == '0);
  assign br_target = idex_pc4 + {idex_imm[XW-3:0], 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exmem_valid <= 1'b0;
      exmem_we    <= 1'b0;
      exmem_rd    <= 1'b0;
      exmem_wr    <= 1'b0;
      exmem_dest  <= '0;
      exmem_y     <= '0;
      exmem_store <= '0;
    end else begin
      exmem_valid <= run && idex_valid;
      exmem_we    <= idex_ctrl.reg_we;
      exmem_rd    <= idex_ctrl.mem_rd;
      exmem_wr    <= idex_ctrl.mem_wr;
      exmem_dest  <= idex_ctrl.dest;
      exmem_y     <= ex_y;
      exmem_store <= idex_b;
    end
  end

  // ---------------- memory ----------------
  assign dm_idx     = exmem_y[MEM_AW+1:2];
  assign dm_we      = run && exmem_valid && exmem_wr;
  assign mem_result = exmem_rd ? dmem[dm_idx] : exmem_y;

  always_ff @(posedge clk) begin
    if (ld_fire && ld_sel) dmem[ld_addr] <= ld_data;
    else if (dm_we)        dmem[dm_idx]  <= exmem_store;
  end

  assign dbg_mem_data = dmem[dbg_mem_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      memwb_valid <= 1'b0;
      memwb_we    <= 1'b0;
      memwb_dest  <= '0;
      memwb_data  <= '0;
    end else begin
      memwb_valid <= run && exmem_valid;
      memwb_we    <= exmem_we;
      memwb_dest  <= exmem_dest;
      memwb_data  <= mem_result;
    end
  end

  // ---------------- write-back ----------------
  assign rf_we    = memwb_valid && memwb_we;
  assign rf_waddr = memwb_dest;
endmodule

// File: rtl/pipe_core_chk.sv
module pipe_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic        stall,
  input logic        br_taken,
  input logic [31:0] br_target,
  input logic [31:0] pc,
  input logic        ifid_valid,
  input logic        idex_valid,
  input logic        rf_we,
  input logic [4:0]  rf_waddr,
  input logic        dm_we,
  input logic        ld_valid,
  input logic        ld_ready
);
  // R6: no write-back ever targets register 0
  assert_r0_unwritten_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_waddr != 5'd0));

  // R7: a stall freezes the program counter
  assert_stall_holds_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && stall && !br_taken) |=> (!run || pc == $past(pc)));

  // R7: a stall sends a bubble into execute
  assert_stall_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && stall) |=> !idex_valid);

  // R9: a taken branch empties the two younger slots
  assert_branch_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && br_taken) |=> (!ifid_valid && !idex_valid));

  // R9: fetch resumes at the branch target
  assert_branch_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && br_taken) |=> (!run || pc == $past(br_target)));

  // R10: no handshake can complete while running, and no store happens while idle
  assert_load_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ld_valid) |-> !ld_ready);

  assert_idle_no_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !dm_we);
endmodule

bind pipe_core pipe_core_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .stall      (stall),
  .br_taken   (br_taken),
  .br_target  (br_target),
  .pc         (pc),
  .ifid_valid (ifid_valid),
  .idex_valid (idex_valid),
  .rf_we      (rf_we),
  .rf_waddr   (rf_waddr),
  .dm_we      (dm_we),
  .ld_valid   (ld_valid),
  .ld_ready   (ld_ready)
);

// File: tb/tb_pipe_core.sv
`timescale 1ns/1ps
module tb_pipe_core;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run = 1'b0;
  logic          ld_valid = 1'b0;
  logic          ld_ready;
  logic          ld_sel = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0]   ld_data = '0;
  logic [4:0]    dbg_reg_addr = '0;
  logic [31:0]   dbg_reg_data;
  logic [AW-1:0] dbg_mem_addr = '0;
  logic [31:0]   dbg_mem_data;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  pipe_core #(.MEM_AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .run(run),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_sel(ld_sel),
    .ld_addr(ld_addr), .ld_data(ld_data),
    .dbg_reg_addr(dbg_reg_addr), .dbg_reg_data(dbg_reg_data),
    .dbg_mem_addr(dbg_mem_addr), .dbg_mem_data(dbg_mem_data)
  );

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] halt_word();
    return enc_i(6'h04, 0, 0, -1);
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    run = 1'b0;
    ld_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic put(input logic sel, input int idx, input logic [31:0] w);
    ld_sel = sel;
    ld_addr = AW'(idx);
    ld_data = w;
    ld_valid = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic clear_imem();
    for (int i = 0; i < DEPTH; i++) put(1'b0, i, 32'h0);
  endtask

  task automatic run_for(input int n);
    run = 1'b1;
    repeat (n) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] reg_now(input int r);
    return 32'h0;
  endfunction

  task automatic chk_reg(input string req, input int r, input logic [31:0] exp);
    dbg_reg_addr = 5'(r);
    #1;
    check(req, $sformatf("r%0d", r), dbg_reg_data, exp);
  endtask

  task automatic chk_mem(input string req, input int idx, input logic [31:0] exp);
    dbg_mem_addr = AW'(idx);
    #1;
    check(req, $sformatf("dmem[%0d]", idx), dbg_mem_data, exp);
  endtask

  task automatic t_reset();
    do_reset();
    for (int r = 0; r < 32; r++) chk_reg("R1", r, 32'h0);
    check("R1", "ld_ready idle", {31'b0, ld_ready}, 32'h1);
  endtask

  task automatic t_alu();
    do_reset();
    clear_imem();
    put(1'b1, 0, 32'hFFFF_FFFD);
    put(1'b1, 1, 32'd7);
    put(1'b0, 0, enc_i(6'h23, 0, 1, 0));
    put(1'b0, 1, enc_i(6'h23, 0, 2, 4));
    put(1'b0, 2, enc_r(6'h20, 3, 1, 2));
    put(1'b0, 3, enc_r(6'h22, 4, 1, 2));
    put(1'b0, 4, enc_r(6'h24, 5, 1, 2));
    put(1'b0, 5, enc_r(6'h25, 6, 1, 2));
    put(1'b0, 6, enc_r(6'h2A, 7, 1, 2));
    put(1'b0, 7, enc_r(6'h2A, 8, 2, 1));
    put(1'b0, 8, enc_r(6'h3F, 9, 1, 2));
    put(1'b0, 9, halt_word());
    run_for(60);
    chk_reg("R3", 3, 32'd4);
    chk_reg("R3", 4, 32'hFFFF_FFF6);
    chk_reg("R3", 5, 32'd5);
    chk_reg("R3", 6, 32'hFFFF_FFFF);
    chk_reg("R3", 9, 32'h0);
    chk_reg("R4", 7, 32'd1);
    chk_reg("R4", 8, 32'd0);
  endtask

  task automatic t_mem();
    do_reset();
    clear_imem();
    put(1'b1, 3, 32'd40);
    put(1'b1, 0, 32'hA5);
    put(1'b1, 9, 32'h1234);
    put(1'b1, 8, 32'h0);
    put(1'b0, 0, enc_i(6'h23, 0, 9, 12));
    put(1'b0, 1, enc_i(6'h23, 0, 1, 0));
    put(1'b0, 2, enc_i(6'h2B, 9, 1, -8));
    put(1'b0, 3, enc_i(6'h23, 9, 10, -4));
    put(1'b0, 4, enc_i(6'h23, 9, 11, -8));
    put(1'b0, 5, halt_word());
    run_for(60);
    chk_mem("R5", 8, 32'hA5);
    chk_reg("R5", 10, 32'h1234);
    chk_reg("R5", 11, 32'hA5);
  endtask

  task automatic t_r0();
    do_reset();
    clear_imem();
    put(1'b1, 0, 32'd9);
    put(1'b0, 0, enc_i(6'h23, 0, 1, 0));
    put(1'b0, 1, enc_r(6'h20, 0, 1, 1));
    put(1'b0, 2, enc_r(6'h20, 12, 0, 1));
    put(1'b0, 3, enc_i(6'h23, 0, 0, 0));
    put(1'b0, 4, enc_r(6'h25, 13, 0, 0));
    put(1'b0, 5, halt_word());
    run_for(60);
    chk_reg("R6", 0, 32'h0);
    chk_reg("R6", 12, 32'd9);
    chk_reg("R6", 13, 32'h0);
  endtask

  task automatic t_deps();
    do_reset();
    clear_imem();
    put(1'b1, 0, 32'd3);
    put(1'b0, 0, enc_i(6'h23, 0, 1, 0));
    put(1'b0, 1, enc_r(6'h20, 2, 1, 1));
    put(1'b0, 2, enc_r(6'h20, 3, 2, 1));
    put(1'b0, 3, enc_r(6'h22, 4, 3, 2));
    put(1'b0, 4, enc_r(6'h25, 5, 0, 0));
    put(1'b0, 5, enc_r(6'h25, 6, 0, 0));
    put(1'b0, 6, enc_r(6'h20, 7, 4, 4));
    put(1'b0, 7, halt_word());
    run_for(60);
    chk_reg("R7", 2, 32'd6);
    chk_reg("R7", 3, 32'd9);
    chk_reg("R7", 4, 32'd3);
    chk_reg("R8", 7, 32'd6);
  endtask

  task automatic t_branch();
    do_reset();
    clear_imem();
    put(1'b1, 0, 32'd5);
    put(1'b1, 1, 32'd5);
    put(1'b0, 0, enc_i(6'h23, 0, 1, 0));
    put(1'b0, 1, enc_i(6'h23, 0, 2, 4));
    put(1'b0, 2, enc_i(6'h04, 1, 2, 4));
    put(1'b0, 3, enc_r(6'h20, 3, 1, 2));
    put(1'b0, 4, enc_r(6'h20, 4, 1, 2));
    put(1'b0, 5, enc_r(6'h20, 5, 1, 2));
    put(1'b0, 6, enc_r(6'h20, 6, 1, 2));
    put(1'b0, 7, enc_r(6'h20, 7, 1, 2));
    put(1'b0, 8, enc_i(6'h04, 1, 0, 5));
    put(1'b0, 9, enc_r(6'h25, 8, 1, 2));
    put(1'b0, 10, halt_word());
    run_for(80);
    chk_reg("R9", 3, 32'h0);
    chk_reg("R9", 4, 32'h0);
    chk_reg("R9", 5, 32'h0);
    chk_reg("R9", 6, 32'h0);
    chk_reg("R9", 7, 32'd10);
    chk_reg("R9", 8, 32'd5);
  endtask

  task automatic t_load_port();
    do_reset();
    clear_imem();
    put(1'b0, 0, halt_word());
    put(1'b1, 20, 32'hCAFE);
    chk_mem("R2", 20, 32'hCAFE);
    put(1'b0, 1, 32'h0);
    run = 1'b1;
    repeat (3) @(negedge clk);
    ld_sel = 1'b1;
    ld_addr = AW'(20);
    ld_data = 32'hDEAD;
    ld_valid = 1'b1;
    #1;
    check("R10", "ld_ready running", {31'b0, ld_ready}, 32'h0);
    repeat (2) @(negedge clk);
    ld_valid = 1'b0;
    run = 1'b0;
    @(negedge clk);
    chk_mem("R10", 20, 32'hCAFE);
    check("R2", "ld_ready idle again", {31'b0, ld_ready}, 32'h1);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_alu();
    t_mem();
    t_r0();
    t_deps();
    t_branch();
    t_load_port();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule